// File: doc/BRIEF.md
# Process-Tagged Translation Cache with Least-Recently-Used Replacement

This block is a small fully associative cache of page-to-frame translations. Each line holds a virtual page number, the address-space tag of the process that owns it, a physical frame number and five attribute bits: kernel-only, readable, writable, executable and dirty. A lookup presents a page number, the current address-space tag, the access kind and the privilege level. In the same cycle the block returns one of three results. A permitted match is a hit and carries the frame number. A match that the permissions forbid is a protection fault. No match is a miss, which tells the external table walker to fetch the mapping.

The walker hands the fetched mapping back through the refill port. The refill goes into the line that already holds the same page and tag if there is one. Otherwise it takes the lowest free line. Once every line is occupied, it takes the line that was touched longest ago, counting both hits and refills as touches. Lines are tagged by process, so a context switch can leave the cache alone. A flush can still drop every line, or only the lines of one tag.

Top module: `tlb_tagged`

## Requirements
- R1: After reset every line is invalid, so every lookup reports a miss until a refill has completed.
- R2: A lookup whose page number and tag match a valid line, and which that line permits, raises `hit` and drives that line's frame number on `frame`, in the same cycle.
- R3: A lookup with no valid line matching both page number and tag raises `miss`, keeps `hit` low and drives zero on `frame`. A line with the same page number under another tag does not match.
- R4: `lk_kind` encodes 0 = read, 1 = write, 2 = instruction fetch and 3 = read. A matching line faults when it is kernel-only and `lk_priv` is 0, or when the needed right is clear. A fault raises `fault` with `hit` low and `frame` zero, and it changes neither the recency order nor the dirty bits.
- R5: A permitted write to a line whose dirty bit is clear pulses `dirty_set` in that cycle and sets the bit. A later write to the same line gives no pulse.
- R6: `fill_perm` packs kernel-only in bit 3, read in bit 2, write in bit 1 and execute in bit 0. A refill whose page and tag are already cached overwrites that line. Otherwise the refill takes the lowest-numbered invalid line. The new mapping is visible from the next cycle.
- R7: When all lines are valid and the refill matches none of them, the refill replaces the line least recently touched. Both a hit and a refill count as a touch.
- R8: `flush` with `flush_by_tag` low invalidates every line in one cycle.
- R9: `flush` with `flush_by_tag` high invalidates only the lines whose tag equals `flush_tag`.
- R10: When a flush and a refill arrive in the same cycle, the refill is dropped. A lookup in a cycle that also carries a flush or a refill still reports a result from the current contents. That lookup does not touch the recency order, set a dirty bit or pulse `dirty_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_asid | input | 8 | Address-space tag of the running process |
| lk_kind | input | 2 | Access kind (0 read, 1 write, 2 fetch, 3 read) |
| lk_priv | input | 1 | 1 when the access is made in kernel mode |
| hit | output | 1 | Permitted translation found |
| miss | output | 1 | No matching line; the page tables must be walked |
| fault | output | 1 | Matching line forbids this access |
| frame | output | 20 | Frame number on a hit, zero otherwise |
| dirty_set | output | 1 | A write has just marked a clean line dirty |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | 20 | Page number of the refilled mapping |
| fill_asid | input | 8 | Tag of the refilled mapping |
| fill_pfn | input | 20 | Frame number of the refilled mapping |
| fill_perm | input | 4 | Kernel, read, write, execute bits (3 down to 0) |
| fill_dirty | input | 1 | Initial dirty bit of the refilled line |
| flush | input | 1 | Invalidate lines |
| flush_by_tag | input | 1 | Limit the flush to one tag |
| flush_tag | input | 8 | Tag selected by a limited flush |

## Verification
Corrupted contents or valid bits show at once at the ports. The next lookup of the affected page returns the wrong one of hit, miss or fault, or the wrong frame, so the bench compares every output on every cycle against a behavioural model. A wrong recency order stays hidden until an eviction falls on the wrong line, and that shows only when the evicted page is looked up again. To expose it, the bench fills the cache completely, reorders the lines with hits and then looks up the page it expects to be gone. A lost or stuck dirty bit shows as a missing or repeated `dirty_set` pulse on the next write to that page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_t;

  // Packed so that bit 3 is kernel-only and bit 0 is execute.
  typedef struct packed {
    logic kern;
    logic rd;
    logic wr;
    logic ex;
  } perm_t;

  // True when the access is not allowed by the line's rights.
  function automatic logic perm_violation(input perm_t p, input acc_t a,
                                          input logic priv);
    logic need;
    case (a)
      ACC_WRITE: need = p.wr;
      ACC_FETCH: need = p.ex;
      default:   need = p.rd;
    endcase
    return (p.kern && !priv) || !need;
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int TAG_W = 8
) (
  input  logic [N-1:0]     line_ok,
  input  logic [VPN_W-1:0] line_vpn [N],
  input  logic [TAG_W-1:0] line_tag [N],
  input  logic [VPN_W-1:0] key_vpn,
  input  logic [TAG_W-1:0] key_tag,
  output logic [N-1:0]     match
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = line_ok[i] && (line_vpn[i] == key_vpn) &&
                      (line_tag[i] == key_tag);
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] oldest
);
  // age 0 = most recent, N-1 = least recent; ages always form a permutation
  logic [IW-1:0] age [N];
  logic [IW-1:0] touched_age;

  assign touched_age = age[touch_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)        age[i] <= '0;
        else if (age[i] < touched_age)  age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest = '0;
    for (int i = 0; i < N; i++)
      if (age[i] == IW'(N - 1)) oldest = IW'(i);
  end
endmodule

// File: rtl/tlb_tagged.sv
module tlb_tagged
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int TAG_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [TAG_W-1:0] lk_asid,
  input  logic [1:0]       lk_kind,
  input  logic             lk_priv,
  output logic             hit,
  output logic             miss,
  output logic             fault,
  output logic [PFN_W-1:0] frame,
  output logic             dirty_set,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [TAG_W-1:0] fill_asid,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [3:0]       fill_perm,
  input  logic             fill_dirty,
  input  logic             flush,
  input  logic             flush_by_tag,
  input  logic [TAG_W-1:0] flush_tag
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // line state
  logic [ENTRIES-1:0] e_val, e_dirty;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [TAG_W-1:0]   e_tag  [ENTRIES];
  logic [PFN_W-1:0]   e_pfn  [ENTRIES];
  perm_t              e_perm [ENTRIES];

  logic [ENTRIES-1:0] lk_match, fill_match;
  logic [IW-1:0]      lk_idx, fill_idx, free_idx, lru_idx;
  logic               lk_any, viol, upd_ok, touch_en;

  function automatic logic [IW-1:0] onehot_index(input logic [ENTRIES-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (v[i]) r = r | IW'(i);
    return r;
  endfunction

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_lk_cmp (
    .line_ok(e_val), .line_vpn(e_vpn), .line_tag(e_tag),
    .key_vpn(lk_vpn), .key_tag(lk_asid), .match(lk_match)
  );

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_fill_cmp (
    .line_ok(e_val), .line_vpn(e_vpn), .line_tag(e_tag),
    .key_vpn(fill_vpn), .key_tag(fill_asid), .match(fill_match)
  );

  // lookup result
  assign lk_any = |lk_match;
  assign lk_idx = onehot_index(lk_match);
  assign viol   = perm_violation(e_perm[lk_idx], acc_t'(lk_kind), lk_priv);
  assign upd_ok = !flush && !fill_valid;

  assign hit       = lk_valid && lk_any && !viol;
  assign fault     = lk_valid && lk_any && viol;
  assign miss      = lk_valid && !lk_any;
  assign frame     = hit ? e_pfn[lk_idx] : '0;
  assign dirty_set = hit && (acc_t'(lk_kind) == ACC_WRITE) &&
                     !e_dirty[lk_idx] && upd_ok;

  // refill placement: existing line, then lowest free line, then oldest
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!e_val[i]) free_idx = IW'(i);
  end

  always_comb begin
    if (|fill_match)    fill_idx = onehot_index(fill_match);
    else if (!(&e_val)) fill_idx = free_idx;
    else                fill_idx = lru_idx;
  end

  assign touch_en = !flush && (fill_valid || hit);

  tlb_lru #(.N(ENTRIES)) u_lru (
    .clk(clk), .rst(rst), .touch_en(touch_en),
    .touch_idx(fill_valid ? fill_idx : lk_idx), .oldest(lru_idx)
  );

  // valid and dirty bits carry a reset
  always_ff @(posedge clk) begin
    if (rst) begin
      e_val   <= '0;
      e_dirty <= '0;
    end else if (flush) begin
      for (int i = 0; i < ENTRIES; i++)
        if (!flush_by_tag || (e_tag[i] == flush_tag)) e_val[i] <= 1'b0;
    end else if (fill_valid) begin
      e_val[fill_idx]   <= 1'b1;
      e_dirty[fill_idx] <= fill_dirty;
    end else if (dirty_set) begin
      e_dirty[lk_idx] <= 1'b1;
    end
  end

  // payload: single write port, no reset
  always_ff @(posedge clk) begin
    if (fill_valid && !flush) begin
      e_vpn[fill_idx]  <= fill_vpn;
      e_tag[fill_idx]  <= fill_asid;
      e_pfn[fill_idx]  <= fill_pfn;
      e_perm[fill_idx] <= perm_t'(fill_perm);
    end
  end
endmodule

// File: rtl/tlb_tagged_chk.sv
module tlb_tagged_chk #(
  parameter int VPN_W = 20,
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic [VPN_W-1:0] lk_vpn,
  input logic [TAG_W-1:0] lk_asid,
  input logic             hit,
  input logic             miss,
  input logic             fault,
  input logic             dirty_set,
  input logic             fill_valid,
  input logic [VPN_W-1:0] fill_vpn,
  input logic [TAG_W-1:0] fill_asid,
  input logic             flush,
  input logic             flush_by_tag,
  input logic [TAG_W-1:0] flush_tag
);
  // R6
  refill_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !flush) |=> (!lk_valid || lk_vpn != $past(fill_vpn) ||
                                lk_asid != $past(fill_asid) || !miss));

  // R5
  single_dirty_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (dirty_set && !flush && !fill_valid) |=>
      !(dirty_set && lk_vpn == $past(lk_vpn) && lk_asid == $past(lk_asid)));

  // R8
  flush_all_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (flush && !flush_by_tag) |=> !(hit || fault));

  // R9
  flush_tag_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (flush && flush_by_tag) |=> !((hit || fault) && lk_asid == $past(flush_tag)));
endmodule

bind tlb_tagged tlb_tagged_chk #(.VPN_W(VPN_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
  .lk_asid(lk_asid), .hit(hit), .miss(miss), .fault(fault),
  .dirty_set(dirty_set), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
  .fill_asid(fill_asid), .flush(flush), .flush_by_tag(flush_by_tag),
  .flush_tag(flush_tag)
);

// File: tb/tlb_tagged_bench.sv
`timescale 1ns/1ps
module tlb_tagged_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid, lk_priv, fill_valid, fill_dirty, flush, flush_by_tag;
  logic [19:0] lk_vpn, fill_vpn, fill_pfn;
  logic [7:0]  lk_asid, fill_asid, flush_tag;
  logic [1:0]  lk_kind;
  logic [3:0]  fill_perm;
  logic        hit, miss, fault, dirty_set;
  logic [19:0] frame;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  tlb_tagged u_tlb_tagged (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_asid(lk_asid), .lk_kind(lk_kind), .lk_priv(lk_priv), .hit(hit),
    .miss(miss), .fault(fault), .frame(frame), .dirty_set(dirty_set),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm), .fill_dirty(fill_dirty),
    .flush(flush), .flush_by_tag(flush_by_tag), .flush_tag(flush_tag)
  );

  // behavioural model: lines with a last-use timestamp
  logic [19:0] m_vpn [8];
  logic [7:0]  m_tag [8];
  logic [19:0] m_pfn [8];
  logic [3:0]  m_perm [8];
  bit          m_val [8];
  bit          m_dirty [8];
  int          m_stamp [8];
  int          now_t = 0;

  task automatic idle();
    lk_valid = 0; lk_vpn = 0; lk_asid = 0; lk_kind = 0; lk_priv = 0;
    fill_valid = 0; fill_vpn = 0; fill_asid = 0; fill_pfn = 0;
    fill_perm = 0; fill_dirty = 0;
    flush = 0; flush_by_tag = 0; flush_tag = 0;
  endtask

  task automatic look(input logic [19:0] v, input logic [7:0] t,
                      input logic [1:0] k, input logic p);
    lk_valid = 1; lk_vpn = v; lk_asid = t; lk_kind = k; lk_priv = p;
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] t,
                      input logic [19:0] f, input logic [3:0] pm,
                      input logic d);
    fill_valid = 1; fill_vpn = v; fill_asid = t; fill_pfn = f;
    fill_perm = pm; fill_dirty = d;
  endtask

  // one clock: check outputs mid-cycle, then advance the model at the edge
  task automatic cyc(input string req);
    int  mi;
    bit  v, e_hit, e_miss, e_fault, e_ds;
    logic [19:0] e_frame;
    string lab;
    #1;
    mi = -1;
    for (int i = 0; i < 8; i++)
      if (m_val[i] && m_vpn[i] == lk_vpn && m_tag[i] == lk_asid) mi = i;
    v = 0;
    if (mi >= 0) begin
      if (m_perm[mi][3] && !lk_priv) v = 1;
      else if (lk_kind == 2'd1) v = !m_perm[mi][1];
      else if (lk_kind == 2'd2) v = !m_perm[mi][0];
      else v = !m_perm[mi][2];
    end
    e_hit   = lk_valid && mi >= 0 && !v;
    e_fault = lk_valid && mi >= 0 && v;
    e_miss  = lk_valid && mi < 0;
    e_frame = e_hit ? m_pfn[mi] : 20'd0;
    e_ds    = e_hit && lk_kind == 2'd1 && !m_dirty[mi] && !flush && !fill_valid;
    if (req != "") lab = req;
    else if (e_ds) lab = "R5";
    else if (e_fault) lab = "R4";
    else if (e_hit) lab = "R2";
    else lab = "R3";
    checks++;
    if (hit !== e_hit || miss !== e_miss || fault !== e_fault ||
        frame !== e_frame || dirty_set !== e_ds) begin
      errors++;
      $display("FAIL %s t=%0t vpn=%h tag=%h: got h%b m%b f%b fr=%h d%b exp h%b m%b f%b fr=%h d%b",
               lab, $time, lk_vpn, lk_asid, hit, miss, fault, frame, dirty_set,
               e_hit, e_miss, e_fault, e_frame, e_ds);
    end
    @(posedge clk);
    if (flush) begin
      for (int i = 0; i < 8; i++)
        if (!flush_by_tag || m_tag[i] == flush_tag) m_val[i] = 0;
    end else if (fill_valid) begin
      int ti, oldest;
      ti = -1;
      for (int i = 0; i < 8; i++)
        if (m_val[i] && m_vpn[i] == fill_vpn && m_tag[i] == fill_asid) ti = i;
      if (ti < 0)
        for (int i = 7; i >= 0; i--) if (!m_val[i]) ti = i;
      if (ti < 0) begin
        oldest = 0;
        for (int i = 1; i < 8; i++) if (m_stamp[i] < m_stamp[oldest]) oldest = i;
        ti = oldest;
      end
      m_vpn[ti] = fill_vpn; m_tag[ti] = fill_asid; m_pfn[ti] = fill_pfn;
      m_perm[ti] = fill_perm; m_dirty[ti] = fill_dirty; m_val[ti] = 1;
      now_t++; m_stamp[ti] = now_t;
    end else if (e_hit) begin
      now_t++; m_stamp[mi] = now_t;
      if (e_ds) m_dirty[mi] = 1;
    end
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_val[i] = 0; m_dirty[i] = 0; m_stamp[i] = 0;
      m_vpn[i] = 0; m_tag[i] = 0; m_pfn[i] = 0; m_perm[i] = 0;
    end
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: empty after reset
    look(20'h00100, 8'd1, 2'd0, 1'b1); cyc("R1");
    look(20'h00000, 8'd0, 2'd0, 1'b0); cyc("R1");

    // R6: fill all lines with varied rights, lowest free line first
    for (int i = 0; i < 8; i++) begin
      fill(20'h00100 + 20'(i), 8'd1, 20'hA0000 + 20'(i),
           (i == 3) ? 4'b1111 : (i == 4) ? 4'b0100 : (i == 5) ? 4'b0001 : 4'b0110,
           1'b0);
      cyc("R6");
    end
    // R2: hits on each line
    for (int i = 0; i < 8; i++) begin
      look(20'h00100 + 20'(i), 8'd1, 2'd0, 1'b1); cyc("R2");
    end
    // R3: same page under another tag misses
    look(20'h00102, 8'd2, 2'd0, 1'b1); cyc("R3");
    look(20'h00200, 8'd1, 2'd0, 1'b1); cyc("R3");
    // R4: kernel-only from user, write to read-only, fetch without execute, kind 3
    look(20'h00103, 8'd1, 2'd0, 1'b0); cyc("R4");
    look(20'h00104, 8'd1, 2'd1, 1'b1); cyc("R4");
    look(20'h00100, 8'd1, 2'd2, 1'b1); cyc("R4");
    look(20'h00105, 8'd1, 2'd3, 1'b1); cyc("R4");
    look(20'h00105, 8'd1, 2'd2, 1'b0); cyc("R2");
    // R5: first write pulses, second does not
    look(20'h00101, 8'd1, 2'd1, 1'b0); cyc("R5");
    look(20'h00101, 8'd1, 2'd1, 1'b0); cyc("R5");
    // R6: refill of a cached page overwrites in place
    fill(20'h00102, 8'd1, 20'hBEEF2, 4'b0110, 1'b0); cyc("R6");
    look(20'h00102, 8'd1, 2'd0, 1'b0); cyc("R6");
    // R7: touch all but line 6, then a new page must evict page 0x106
    for (int i = 0; i < 8; i++)
      if (i != 6) begin look(20'h00100 + 20'(i), 8'd1, 2'd0, 1'b1); cyc("R7"); end
    fill(20'h00300, 8'd1, 20'hC0300, 4'b0110, 1'b0); cyc("R7");
    look(20'h00106, 8'd1, 2'd0, 1'b1); cyc("R7");
    look(20'h00300, 8'd1, 2'd0, 1'b1); cyc("R7");
    look(20'h00107, 8'd1, 2'd0, 1'b1); cyc("R7");
    // R9: tagged flush leaves other tags
    fill(20'h00102, 8'd2, 20'hD0002, 4'b0110, 1'b0); cyc("R9");
    flush = 1; flush_by_tag = 1; flush_tag = 8'd1; cyc("R9");
    look(20'h00102, 8'd2, 2'd0, 1'b0); cyc("R9");
    look(20'h00102, 8'd1, 2'd0, 1'b0); cyc("R9");
    // R10: flush and refill together drop the refill
    flush = 1; fill(20'h00400, 8'd3, 20'hE0400, 4'b0110, 1'b0); cyc("R10");
    look(20'h00400, 8'd3, 2'd0, 1'b0); cyc("R10");
    // R10: write lookup during a refill neither pulses nor sets dirty
    fill(20'h00500, 8'd3, 20'hE0500, 4'b0110, 1'b0); cyc("R10");
    look(20'h00500, 8'd3, 2'd1, 1'b0);
    fill(20'h00501, 8'd3, 20'hE0501, 4'b0110, 1'b0); cyc("R10");
    look(20'h00500, 8'd3, 2'd1, 1'b0); cyc("R10");
    // R8: full flush
    flush = 1; look(20'h00500, 8'd3, 2'd0, 1'b0); cyc("R8");
    look(20'h00500, 8'd3, 2'd0, 1'b0); cyc("R8");
    look(20'h00102, 8'd2, 2'd0, 1'b0); cyc("R8");

    // mixed random traffic over a small page space
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 3) != 0)
        look(20'($urandom_range(0, 11)), 8'($urandom_range(0, 2)),
             2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0)
        fill(20'($urandom_range(0, 11)), 8'($urandom_range(0, 2)),
             20'($urandom), 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 59) == 0) begin
        flush = 1; flush_by_tag = 1'($urandom_range(0, 1));
        flush_tag = 8'($urandom_range(0, 2));
      end
      cyc("");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule